// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries a stream of data words from a producer clocked by one clock to a consumer clocked by another, unrelated clock. Words enter through a write port with a write enable and a full flag, both in the write clock domain. They leave through a read port with a read enable and an empty flag, both in the read clock domain. The read port is first-word fall-through: whenever the FIFO is not empty, the oldest word is already on the read data output, and asserting the read enable consumes it.

Each side keeps a binary pointer that is one bit wider than the storage address, together with a registered Gray-coded copy of that pointer. The Gray copy goes straight from its flip-flop into a chain of synchronizer flip-flops clocked by the other domain. The write side computes full only from its own pointer and the synchronized read pointer. The read side computes empty only from its own pointer and the synchronized write pointer. Because the synchronized copies always lag, either flag can stay set for a few cycles longer than strictly needed. This can stall a side for those cycles, but it never lets a word be lost, overwritten or read twice.

Top module: `gfifo_top`

## Requirements
- R1: While a side's synchronous active-high reset is held, its pointer returns to zero. After both resets, empty reads 1 and full reads 0.
- R2: Words leave the read port in the order they were written, with none lost and none duplicated. The oldest unread word is visible on rd_data whenever empty is 0.
- R3: With no reads, full goes to 1 right after the DEPTH-th accepted write (DEPTH = 2**ADDR_W) and is 0 before it. A write while full is ignored and leaves the stored words and the write pointer unchanged.
- R4: A read while empty is ignored and leaves the read pointer unchanged. The next word written is the next word read.
- R5: After a write into an empty FIFO, empty stays 1 through the write edge itself, because the new pointer has not yet crossed. Empty drops to 0 within SYNC_STAGES+1 read clock edges.
- R6: After a read from a full FIFO, full stays 1 through the read edge itself. It drops to 0 within SYNC_STAGES+1 write clock edges.
- R7: Each Gray pointer changes in at most one bit per clock edge of its own domain, and it changes only when a transfer is accepted.
- R8: The pointers wrap past 2*DEPTH. Full, empty and word order stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Write domain synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| full | output | 1 | FIFO full, seen from the write side |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Read domain synchronous reset, active high |
| rd_en | input | 1 | Read request, consumes the word on rd_data |
| rd_data | output | DATA_W | Oldest unread word |
| empty | output | 1 | FIFO empty, seen from the read side |

## Verification
The bench builds the block with its default parameters: 8-bit words, ADDR_W = 3 (eight entries, 4-bit pointers) and two synchronizer stages. The write clock runs at 100 MHz and the read clock runs more slowly on an unrelated 14 ns period. With only eight entries, a forty-word streaming run wraps both pointers several times and keeps the writer repeatedly stalled on full. Filling the FIFO outright, and reading or writing at the wrong moment, are then each a handful of cycles. The short two-stage chain keeps the flag lag in R5 and R6 small, so it can be checked at exact edge counts.

// File: rtl/gfifo_pkg.sv
package gfifo_pkg;

    localparam int unsigned GRAY_MAX_W = 32;

    // binary to reflected Gray code, caller truncates to its width
    function automatic logic [GRAY_MAX_W-1:0] to_gray(input logic [GRAY_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // mask that turns a Gray pointer into the value it holds one full lap ahead
    function automatic logic [GRAY_MAX_W-1:0] lap_mask(input int unsigned ptr_w);
        return GRAY_MAX_W'(3) << (ptr_w - 2);
    endfunction

endpackage

// File: rtl/gfifo_sync.sv
module gfifo_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gfifo_wptr.sv
module gfifo_wptr
    import gfifo_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rd_gray_s,
    output logic              full,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray
);
    localparam int unsigned PW = ADDR_W + 1;
    localparam logic [PW-1:0] LAP = PW'(lap_mask(PW));

    logic [PW-1:0] bin_q, bin_n, gray_q;

    assign full    = (gray_q == (rd_gray_s ^ LAP));
    assign wr_fire = wr_en && !full;
    assign bin_n   = bin_q + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (wr_fire) begin
            bin_q  <= bin_n;
            gray_q <= PW'(to_gray(GRAY_MAX_W'(bin_n)));
        end
    end

    assign wr_addr = bin_q[ADDR_W-1:0];
    assign wr_gray = gray_q;
endmodule

// File: rtl/gfifo_rptr.sv
module gfifo_rptr
    import gfifo_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_gray_s,
    output logic              empty,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray
);
    localparam int unsigned PW = ADDR_W + 1;

    logic [PW-1:0] bin_q, bin_n, gray_q;
    logic          take;

    assign empty = (gray_q == wr_gray_s);
    assign take  = rd_en && !empty;
    assign bin_n = bin_q + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (take) begin
            bin_q  <= bin_n;
            gray_q <= PW'(to_gray(GRAY_MAX_W'(bin_n)));
        end
    end

    assign rd_addr = bin_q[ADDR_W-1:0];
    assign rd_gray = gray_q;
endmodule

// File: rtl/gfifo_mem.sv
module gfifo_mem #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/gfifo_top.sv
module gfifo_top #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    localparam int unsigned PW = ADDR_W + 1;

    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;

    gfifo_wptr #(.ADDR_W(ADDR_W)) wptr_i (
        .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rd_gray_s(rd_gray_s),
        .full(full), .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_gray(wr_gray)
    );

    gfifo_rptr #(.ADDR_W(ADDR_W)) rptr_i (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wr_gray_s(wr_gray_s),
        .empty(empty), .rd_addr(rd_addr), .rd_gray(rd_gray)
    );

    gfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) w2r_i (
        .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_s)
    );

    gfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) r2w_i (
        .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_s)
    );

    gfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .wr_clk(wr_clk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/gfifo_chk.sv
module gfifo_chk #(
    parameter int unsigned PW = 4
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_en,
    input logic          full,
    input logic [PW-1:0] wr_gray,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_en,
    input logic          empty,
    input logic [PW-1:0] rd_gray
);
    // R1: flags leave reset in the idle state
    a_r1_full_clear: assert property (@(posedge wr_clk)
        $past(wr_rst) |-> !full);
    a_r1_empty_set: assert property (@(posedge rd_clk)
        $past(rd_rst) |-> empty);

    // R3: a write against full does not move the write pointer
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && full) |=> $stable(wr_gray));

    // R4: a read against empty does not move the read pointer
    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && empty) |=> $stable(rd_gray));

    // R7: single-bit Gray steps on each side
    a_r7_wr_gray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !$past(wr_rst) |-> ($countones(wr_gray ^ $past(wr_gray)) <= 1));
    a_r7_rd_gray_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !$past(rd_rst) |-> ($countones(rd_gray ^ $past(rd_gray)) <= 1));

    // R7: pointers idle when no request is made
    a_r7_wr_idle: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !wr_en |=> $stable(wr_gray));
    a_r7_rd_idle: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_en |=> $stable(rd_gray));
endmodule

bind gfifo_top gfifo_chk #(.PW(ADDR_W + 1)) chk_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .full(full), .wr_gray(wr_gray),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .empty(empty), .rd_gray(rd_gray)
);

// File: tb/gfifo_tb.sv
`timescale 1ns/1ps
module gfifo_top_tb_top;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LAG    = 3;  // SYNC_STAGES + 1

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst = 1, rd_rst = 1;
    logic wr_en = 0, rd_en = 0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic full, empty;

    int n_tests = 0, n_fail = 0;
    logic [DATA_W-1:0] exp_q[$];

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    gfifo_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut_i (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DATA_W-1:0] d);
        @(negedge wr_clk);
        wr_en = 1; wr_data = d;
        @(posedge wr_clk); #1;
        wr_en = 0;
    endtask

    task automatic pop(output logic [DATA_W-1:0] d);
        @(negedge rd_clk);
        while (empty) @(negedge rd_clk);
        d = rd_data; rd_en = 1;
        @(posedge rd_clk); #1;
        rd_en = 0;
    endtask

    task automatic t_reset();
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk); wr_rst = 0;
        @(negedge rd_clk); rd_rst = 0;
        @(negedge rd_clk);
        check(empty === 1'b1, "R1 empty after reset", empty, 1);
        @(negedge wr_clk);
        check(full === 1'b0, "R1 full after reset", full, 0);
    endtask

    task automatic t_empty_lag();
        logic [DATA_W-1:0] d;
        push(8'h5A);
        check(empty === 1'b1, "R5 empty held at write edge", empty, 1);
        repeat (LAG) @(posedge rd_clk); #1;
        check(empty === 1'b0, "R5 empty released after sync", empty, 0);
        pop(d);
        check(d == 8'h5A, "R2 single word", d, 8'h5A);
        repeat (2) @(posedge rd_clk); #1;
        check(empty === 1'b1, "R2 empty after drain", empty, 1);
    endtask

    task automatic t_underflow();
        logic [DATA_W-1:0] d;
        @(negedge rd_clk); rd_en = 1;
        repeat (4) @(negedge rd_clk);
        rd_en = 0;
        check(empty === 1'b1, "R4 empty after reads on empty", empty, 1);
        push(8'h33);
        pop(d);
        check(d == 8'h33, "R4 next word after ignored reads", d, 8'h33);
        repeat (LAG) @(posedge rd_clk); #1;
        check(empty === 1'b1, "R4 empty again", empty, 1);
    endtask

    task automatic t_full();
        logic [DATA_W-1:0] d;
        repeat (LAG) @(posedge wr_clk);
        for (int i = 0; i < DEPTH; i++) begin
            if (i == DEPTH - 1)
                check(full === 1'b0, "R3 not full before last write", full, 0);
            push(8'(i * 17 + 1));
        end
        check(full === 1'b1, "R3 full after DEPTH writes", full, 1);
        push(8'hEE);
        check(full === 1'b1, "R3 still full after extra write", full, 1);
        // R6: release lag
        pop(d);
        check(d == 8'h01, "R3 first word kept", d, 1);
        check(full === 1'b1, "R6 full held at read edge", full, 1);
        repeat (LAG) @(posedge wr_clk); #1;
        check(full === 1'b0, "R6 full released after sync", full, 0);
        for (int i = 1; i < DEPTH; i++) begin
            pop(d);
            check(d == 8'(i * 17 + 1), "R3 stored words intact", d, 8'(i * 17 + 1));
        end
        repeat (LAG) @(posedge rd_clk); #1;
        check(empty === 1'b1, "R3 dropped word never read", empty, 1);
    endtask

    task automatic t_stream();
        localparam int N = 40;
        fork
            begin : writer
                int wi = 0;
                while (wi < N) begin
                    @(negedge wr_clk);
                    if (!full) begin
                        wr_en = 1; wr_data = 8'(wi * 37 + 11);
                        exp_q.push_back(8'(wi * 37 + 11));
                        wi++;
                    end else wr_en = 0;
                end
                @(negedge wr_clk); wr_en = 0;
            end
            begin : reader
                int ri = 0;
                logic [DATA_W-1:0] e;
                while (ri < N) begin
                    @(negedge rd_clk);
                    if (!empty) begin
                        e = exp_q.pop_front();
                        check(rd_data == e, "R8 R2 stream order across wrap", rd_data, e);
                        rd_en = 1; ri++;
                    end else rd_en = 0;
                end
                @(negedge rd_clk); rd_en = 0;
            end
        join
        repeat (LAG) @(posedge rd_clk); #1;
        check(empty === 1'b1, "R8 empty after stream", empty, 1);
        check(exp_q.size() == 0, "R2 no extra words", exp_q.size(), 0);
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_empty_lag();
        t_underflow();
        t_full();
        t_stream();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule